// File: doc/BRIEF.md
# Sync Slicer and Back-Porch Timer

This block sits behind a free-running 8-bit converter that digitizes ac-coupled composite video. Each enabled sample is compared with two fixed levels. The lower comparison drives a clamp-control bit, which charges the coupling capacitor through an external diode whenever the code falls under the sync-tip target. The higher comparison slices out the horizontal sync pulse.

The width of every sync pulse is measured in samples by a counter that counts up while sync is low. When the trailing edge arrives, the counter latches that width as N and then counts back down to zero. Two timing pulses are derived from this descent, so their position follows the sync width that was just measured rather than fixed line constants:
- A porch gate opens when the count equals three quarters of N and closes at one quarter of N. This window covers the colour burst.
- A line-clear pulse runs from the trailing edge until the gate opens.

Top module: `sync_gate_timer`

## Requirements
- R1: `clamp_o` is 1 when the last enabled sample is below 4 and 0 otherwise. It updates on the clock edge that takes the sample.
- R2: `sync_o` is 1 when the last enabled sample is below 16 and 0 otherwise. It has the same timing as R1.
- R3: N is the number of consecutive enabled samples below 16. The first such sample counts as 1, and the count advances once per enabled sample.
- R4: After the trailing edge the count descends from N by one per enabled sample. It stops at 0 and stays there until the next sync pulse.
- R5: Let the first enabled sample at or above 16 after a sync run of N samples have index f. Then `gate_o` rises on the edge of sample f+2+N-H, where H=(N>>1)+(N>>2) truncated. It falls on the edge of sample f+2+N-L, where L=N>>2.
- R6: `line_clr_o` rises on the edge of sample f+1 and falls on the edge where `gate_o` rises. It is never high together with `gate_o`.
- R7: The up count saturates at 255. A sync run longer than 255 samples behaves as N=255, so the gate opens at count 190 and closes at count 63.
- R8: A new sync pulse that starts while the gate or the clear pulse is active drops both. This happens on the edge of the enabled sample after the first low sample, and the new pulse is then measured from 1.
- R9: When N=1 (H equals L), `gate_o` never rises, and `line_clr_o` falls on the edge of sample f+3.
- R10: The active-low asynchronous reset forces all four outputs to 0 and clears the timer. No gate or clear pulse follows the release until a new sync pulse arrives.
- R11: On a clock with `sample_en_i` low, no output and no internal count changes. All timing above is counted in enabled samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Qualifies `sample_i` on this clock |
| sample_i | input | 8 | Converter output code |
| clamp_o | output | 1 | Charge request for the coupling capacitor |
| sync_o | output | 1 | Sliced horizontal sync |
| gate_o | output | 1 | Back-porch gate around the burst |
| line_clr_o | output | 1 | Per-line clear pulse |

## Verification
The bench targets the following corner cases, each of which a faulty design would get wrong in a visible way:
- **Threshold codes 3, 4, 15 and 16.** An off-by-one comparator would clamp on the sync-tip code itself or slice one code too high.
- **Gate edge positions for widths 18 and 10.** A timer that miscounts the first sample, decrements on the trailing-edge sample, or rounds 3N/4 differently would move the gate by one sample.
- **A 300-sample sync.** This catches a counter that wraps instead of saturating, which would place the gate at N=44.
- **A resync inside the porch, a one-sample pulse, gapped enables and a mid-line reset.** These catch a gate left open, a clear pulse that never ends, counting on idle clocks, and stale timer state.

// File: rtl/sgt_pkg.sv
package sgt_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned CLAMP_LVL = 4;
  localparam int unsigned SLICE_LVL = 16;
endpackage

// File: rtl/sgt_slicer.sv
module sgt_slicer #(
  parameter int unsigned DATA_W    = sgt_pkg::DATA_W,
  parameter int unsigned CLAMP_LVL = sgt_pkg::CLAMP_LVL,
  parameter int unsigned SLICE_LVL = sgt_pkg::SLICE_LVL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              clamp_o,
  output logic              sync_o
);
  localparam logic [DATA_W-1:0] ClampCode = DATA_W'(CLAMP_LVL);
  localparam logic [DATA_W-1:0] SliceCode = DATA_W'(SLICE_LVL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clamp_o <= 1'b0;
      sync_o  <= 1'b0;
    end else if (en_i) begin
      clamp_o <= sample_i < ClampCode;
      sync_o  <= sample_i < SliceCode;
    end
  end

  AST_CLAMP_IN_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_o |-> sync_o); // R1
  AST_HOLD_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable({clamp_o, sync_o})); // R11
endmodule

// File: rtl/sgt_width_timer.sv
module sgt_width_timer #(
  parameter int unsigned CNT_W = sgt_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sync_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic             down_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] n_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic sync_prev;

  assign rise_o = en_i & sync_i & ~sync_prev;
  assign fall_o = en_i & ~sync_i & sync_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_prev <= 1'b0;
      down_o    <= 1'b0;
      cnt_o     <= '0;
      n_o       <= '0;
    end else if (en_i) begin
      sync_prev <= sync_i;
      if (sync_i) begin
        down_o <= 1'b0;
        if (rise_o)              cnt_o <= CNT_W'(1);
        else if (cnt_o != CntMax) cnt_o <= cnt_o + 1'b1; // saturate
      end else if (fall_o) begin
        n_o    <= cnt_o;
        down_o <= 1'b1;
      end else if (down_o && cnt_o != '0) begin
        cnt_o <= cnt_o - 1'b1;
      end
    end
  end

  AST_N_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(down_o) |-> n_o == $past(cnt_o)); // R3
  AST_DOWN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (down_o && cnt_o == '0 && !(en_i && sync_i)) |=> cnt_o == '0); // R4
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sync_i && !rise_o && cnt_o == CntMax) |=> cnt_o == CntMax); // R7
endmodule

// File: rtl/sgt_gate_gen.sv
module sgt_gate_gen #(
  parameter int unsigned CNT_W = sgt_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             gate_o,
  output logic             clr_o
);
  logic [CNT_W-1:0] hi_mark, lo_mark;
  logic             open_hit;

  assign hi_mark  = (n_i >> 1) + (n_i >> 2);
  assign lo_mark  = n_i >> 2;
  // equal marks (N=1) never open the gate
  assign open_hit = (cnt_i == hi_mark) && (hi_mark != lo_mark);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_o <= 1'b0;
      clr_o  <= 1'b0;
    end else if (en_i) begin
      if (rise_i) begin
        gate_o <= 1'b0;
        clr_o  <= 1'b0;
      end else if (fall_i) begin
        gate_o <= 1'b0;
        clr_o  <= 1'b1;
      end else if (down_i) begin
        if (open_hit) begin
          gate_o <= 1'b1;
          clr_o  <= 1'b0;
        end else if (cnt_i == lo_mark) begin
          gate_o <= 1'b0;
          clr_o  <= 1'b0;
        end
      end
    end
  end

  AST_GATE_CLR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o && clr_o)); // R6
  AST_GATE_IN_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> down_i); // R5
endmodule

// File: rtl/sync_gate_timer.sv
module sync_gate_timer #(
  parameter int unsigned DATA_W    = sgt_pkg::DATA_W,
  parameter int unsigned CNT_W     = sgt_pkg::CNT_W,
  parameter int unsigned CLAMP_LVL = sgt_pkg::CLAMP_LVL,
  parameter int unsigned SLICE_LVL = sgt_pkg::SLICE_LVL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_en_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              clamp_o,
  output logic              sync_o,
  output logic              gate_o,
  output logic              line_clr_o
);
  logic             rise, fall, down;
  logic [CNT_W-1:0] cnt, n_meas;

  sgt_slicer #(
    .DATA_W(DATA_W), .CLAMP_LVL(CLAMP_LVL), .SLICE_LVL(SLICE_LVL)
  ) u_slicer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sample_en_i), .sample_i(sample_i),
    .clamp_o(clamp_o), .sync_o(sync_o)
  );

  sgt_width_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sample_en_i), .sync_i(sync_o),
    .rise_o(rise), .fall_o(fall), .down_o(down), .cnt_o(cnt), .n_o(n_meas)
  );

  sgt_gate_gen #(.CNT_W(CNT_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sample_en_i), .rise_i(rise),
    .fall_i(fall), .down_i(down), .cnt_i(cnt), .n_i(n_meas),
    .gate_o(gate_o), .clr_o(line_clr_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> !sync_o); // R5
endmodule

// File: tb/sim_sync_gate_timer.sv
module sim_sync_gate_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_en_i = 1'b0;
  logic [7:0] sample_i = 8'd60;
  logic       clamp_o, sync_o, gate_o, line_clr_o;

  always #4 clk = ~clk;

  sync_gate_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sample_en_i(sample_en_i), .sample_i(sample_i),
    .clamp_o(clamp_o), .sync_o(sync_o), .gate_o(gate_o), .line_clr_o(line_clr_o)
  );

  int checks = 0, fails = 0, idx = 0;
  int g_rise, g_fall, c_rise, c_fall;
  logic pg = 1'b0, pc = 1'b0, pclamp = 1'b0, psync = 1'b0;
  bit gap_bad, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    g_rise = -1; g_fall = -1; c_rise = -1; c_fall = -1; gap_bad = 0;
  endtask

  task automatic push(input logic [7:0] s, input bit en);
    @(negedge clk);
    sample_i = s; sample_en_i = en;
    @(posedge clk); #1;
    if (en) begin
      idx++;
      chk(clamp_o == (s < 8'd4), "R1 clamp level", int'(clamp_o), int'(s < 8'd4));
      chk(sync_o == (s < 8'd16), "R2 sync slice", int'(sync_o), int'(s < 8'd16));
    end else begin
      chk(clamp_o == pclamp && sync_o == psync, "R11 slicer hold",
          int'({clamp_o, sync_o}), int'({pclamp, psync}));
      if (gate_o != pg || line_clr_o != pc) gap_bad = 1;
    end
    if (gate_o && !pg) g_rise = idx;
    if (!gate_o && pg) g_fall = idx;
    if (line_clr_o && !pc) c_rise = idx;
    if (!line_clr_o && pc) c_fall = idx;
    pg = gate_o; pc = line_clr_o; pclamp = clamp_o; psync = sync_o;
  endtask

  task automatic run_line(input int w, input int tail, input bit gaps, input string tag);
    int n, hi, lo, f;
    clear_ev();
    for (int i = 0; i < w; i++) begin
      if (gaps) push(8'd200, 1'b0);
      push((i % 2) ? 8'd9 : 8'd2, 1'b1);
    end
    f = idx + 1;
    for (int i = 0; i < tail; i++) begin
      if (gaps) push(8'd200, 1'b0);
      push((i % 2) ? 8'd120 : 8'd40, 1'b1);
    end
    n  = (w > 255) ? 255 : w;
    hi = (n >> 1) + (n >> 2);
    lo = n >> 2;
    chk(c_rise == f + 1, {tag, " R6 clr rise"}, c_rise, f + 1);
    if (hi != lo) begin
      chk(g_rise == f + 2 + n - hi, {tag, " R3 R4 R5 gate open"}, g_rise, f + 2 + n - hi);
      chk(g_fall == f + 2 + n - lo, {tag, " R4 R5 gate close"}, g_fall, f + 2 + n - lo);
      chk(c_fall == g_rise, {tag, " R6 clr ends at gate"}, c_fall, g_rise);
    end else begin
      chk(g_rise == -1, {tag, " R9 no gate"}, g_rise, -1);
      chk(c_fall == f + 3, {tag, " R9 clr end"}, c_fall, f + 3);
    end
    if (gaps) chk(!gap_bad, {tag, " R11 outputs held without enable"}, int'(gap_bad), 0);
  endtask

  task automatic thresholds();
    push(8'd3, 1'b1); push(8'd4, 1'b1); push(8'd15, 1'b1); push(8'd16, 1'b1);
    push(8'd0, 1'b1); push(8'd255, 1'b1);
    for (int i = 0; i < 20; i++) push(8'd60, 1'b1);
  endtask

  task automatic porch_resync();
    int f, f2;
    clear_ev();
    for (int i = 0; i < 18; i++) push(8'd5, 1'b1);
    f = idx + 1;
    for (int i = 0; i < 8; i++) push(8'd90, 1'b1);
    chk(g_rise == f + 7, "R8 gate open before resync", g_rise, f + 7);
    push(8'd2, 1'b1);
    push(8'd2, 1'b1);
    chk(!gate_o && !line_clr_o, "R8 resync drops gate", int'({gate_o, line_clr_o}), 0);
    chk(g_fall == f + 9, "R8 gate drop sample", g_fall, f + 9);
    clear_ev();
    for (int i = 0; i < 8; i++) push(8'd2, 1'b1);
    f2 = idx + 1;
    for (int i = 0; i < 20; i++) push(8'd70, 1'b1);
    chk(g_rise == f2 + 5, "R8 remeasured open", g_rise, f2 + 5);
    chk(g_fall == f2 + 10, "R8 remeasured close", g_fall, f2 + 10);
  endtask

  task automatic mid_reset();
    for (int i = 0; i < 18; i++) push(8'd2, 1'b1);
    for (int i = 0; i < 5; i++) push(8'd80, 1'b1);
    chk(line_clr_o == 1'b1, "R6 clr active before reset", int'(line_clr_o), 1);
    @(negedge clk); rst_ni = 1'b0; #1;
    chk({clamp_o, sync_o, gate_o, line_clr_o} == 4'b0, "R10 async reset clears outputs",
        int'({clamp_o, sync_o, gate_o, line_clr_o}), 0);
    @(negedge clk); rst_ni = 1'b1;
    pg = 1'b0; pc = 1'b0; pclamp = 1'b0; psync = 1'b0;
    clear_ev();
    for (int i = 0; i < 30; i++) push(8'd80, 1'b1);
    chk(g_rise == -1 && c_rise == -1, "R10 no pulse after reset", g_rise, -1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({clamp_o, sync_o, gate_o, line_clr_o} == 4'b0, "R10 reset state",
        int'({clamp_o, sync_o, gate_o, line_clr_o}), 0);
    @(negedge clk); rst_ni = 1'b1;
    thresholds();
    run_line(18, 30, 1'b0, "N18");
    run_line(10, 20, 1'b0, "N10");
    run_line(1, 12, 1'b0, "N1");
    run_line(300, 270, 1'b0, "R7 N300");
    run_line(18, 30, 1'b1, "gapped");
    porch_resync();
    mid_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule